// File: doc/BRIEF.md
# Three-Point Winograd DFT Processing Element (Shift-and-Add)

This block transforms three complex fixed-point samples into their three-point discrete Fourier transform every clock cycle. It is meant as the radix-3 stage of a non-power-of-two FFT, either in a pipelined chain or behind a memory-based scheduler. The arithmetic follows the Winograd small-transform arrangement. The inputs are first combined into a sum and a difference. Each of these is then scaled by one fixed constant. The outputs are formed by a final layer of additions.

Neither constant uses a multiplier. The factor of one and a half and the factor of sin(60°) are each built as a short network of hardwired shifts and two or three adders. Both work on coefficients with 8 fractional bits. Guard bits keep every intermediate value exact. A fixed arithmetic right shift then scales the results back into the sample width.

The interface has no handshake and a fixed latency. A new set of samples can be presented on every cycle. An optional register stage on the inputs trades one cycle of latency for a shorter input path.

Top module: `r3dft_pe`

## Requirements
- R1: Each part of output 0 equals ((in0 + in1 + in2) >>> SHIFT), computed separately for the real and imaginary parts. The result keeps the low W bits.
- R2: Per part, let t1 = in1 + in2, t2 = in1 - in2, and s = in0 + t1 - floor(384·t1/256). Let k(v) = floor(222·v/256). Then out1.re = (s.re + k(t2.im)) >>> SHIFT and out1.im = (s.im - k(t2.re)) >>> SHIFT. For output 2, the sign of the k term is swapped in both parts.
- R3: With the default SHIFT of 2, no input combination makes an output wrap. Every scaled result fits in W signed bits.
- R4: Each constant product is truncated toward minus infinity after the 8 fractional bits are dropped. For example, t2 = +1 gives k = 0, and t2 = -1 gives k = -1.
- R5: A sample set presented before a rising edge appears at the outputs exactly 1 + IN_REG rising edges later. Until then, the outputs still show the previous sample set.
- R6: While rst_n is low, all six outputs are zero, whatever the inputs are.
- R7: When in1 equals in2 in both parts, output 1 equals output 2 in both parts.
- R8: All-zero inputs give all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| x0_re | input | W | Sample 0, real part, two's complement |
| x0_im | input | W | Sample 0, imaginary part |
| x1_re | input | W | Sample 1, real part |
| x1_im | input | W | Sample 1, imaginary part |
| x2_re | input | W | Sample 2, real part |
| x2_im | input | W | Sample 2, imaginary part |
| y0_re | output | W | Bin 0, real part |
| y0_im | output | W | Bin 0, imaginary part |
| y1_re | output | W | Bin 1, real part |
| y1_im | output | W | Bin 1, imaginary part |
| y2_re | output | W | Bin 2, real part |
| y2_im | output | W | Bin 2, imaginary part |

## Verification
With the default input stage, every bin is due two rising edges after its samples are applied. The bench changes the inputs on a falling edge, lets two rising edges pass, and reads all six outputs on the following falling edge. The latency test reads once after a single rising edge, where the old bins must still be present, and once after the second edge, where the new bins must appear. The reset check reads the outputs several edges into reset, while nonzero samples are driven.

// File: rtl/r3dft_pkg.sv
package r3dft_pkg;
    // fractional bits of the constant coefficients
    localparam int COEF_FRAC = 8;
    // integer coefficient values at 2^COEF_FRAC scale
    localparam int K_THREE_HALVES = 384;
    localparam int K_SIN60        = 222;

    typedef enum logic {
        CM_THREE_HALVES = 1'b0,
        CM_SIN60        = 1'b1
    } cmul_kind_e;
endpackage

// File: rtl/r3dft_preadd.sv
module r3dft_preadd #(
    parameter int W  = 18,
    parameter int IW = 22
) (
    input  logic signed [W-1:0]  a,
    input  logic signed [W-1:0]  b,
    output logic signed [IW-1:0] sum,
    output logic signed [IW-1:0] diff
);
    logic signed [IW-1:0] a_x, b_x;

    assign a_x  = IW'(a);
    assign b_x  = IW'(b);
    assign sum  = a_x + b_x;
    assign diff = a_x - b_x;
endmodule

// File: rtl/r3dft_cmul.sv
module r3dft_cmul
    import r3dft_pkg::*;
#(
    parameter int         IW   = 22,
    parameter cmul_kind_e KIND = CM_SIN60
) (
    input  logic signed [IW-1:0] v,
    output logic signed [IW-1:0] p
);
    localparam int AW   = IW + COEF_FRAC + 1;
    localparam int KVAL = (KIND == CM_THREE_HALVES) ? K_THREE_HALVES : K_SIN60;

    logic signed [AW-1:0] ve, acc, dropped;

    assign ve = AW'(v);

    generate
        if (KIND == CM_THREE_HALVES) begin : g_three_halves
            // 384 = 256 + 128
            assign acc = (ve <<< COEF_FRAC) + (ve <<< (COEF_FRAC - 1));
        end else begin : g_sin60
            // 222 = 256 - 32 - 2
            assign acc = (ve <<< COEF_FRAC) - (ve <<< (COEF_FRAC - 3)) - (ve <<< 1);
        end
    endgenerate

    // arithmetic shift drops fraction bits: floor, never rounds
    assign dropped = acc >>> COEF_FRAC;
    assign p       = dropped[IW-1:0];

    logic signed [AW+1:0] exact_ref, back_ref, resid;
    always_comb begin
        exact_ref = (AW+2)'(ve) * (AW+2)'(KVAL);
        back_ref  = (AW+2)'(p) <<< COEF_FRAC;
        resid     = exact_ref - back_ref;
        AST_CMUL_FLOOR: assert (resid >= 0 && resid < (AW+2)'(256))
            else $error("constant product not floored"); // R4
    end
endmodule

// File: rtl/r3dft_pe.sv
module r3dft_pe
    import r3dft_pkg::*;
#(
    parameter int W      = 18,
    parameter int GUARD  = 4,
    parameter int SHIFT  = 2,
    parameter int IN_REG = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] x0_re,
    input  logic signed [W-1:0] x0_im,
    input  logic signed [W-1:0] x1_re,
    input  logic signed [W-1:0] x1_im,
    input  logic signed [W-1:0] x2_re,
    input  logic signed [W-1:0] x2_im,
    output logic signed [W-1:0] y0_re,
    output logic signed [W-1:0] y0_im,
    output logic signed [W-1:0] y1_re,
    output logic signed [W-1:0] y1_im,
    output logic signed [W-1:0] y2_re,
    output logic signed [W-1:0] y2_im
);
    localparam int IW  = W + GUARD;
    localparam int LAT = 1 + IN_REG;

    typedef logic [W-1:0] samp_t;
    typedef struct packed {
        samp_t [2:0][1:0] x;   // [sample][0=re,1=im]
        samp_t [2:0][1:0] y;   // [bin][0=re,1=im]
    } st_t;

    st_t st_d, st_q;
    samp_t [2:0][1:0] xp, xs;

    assign xp[0][0] = x0_re;
    assign xp[0][1] = x0_im;
    assign xp[1][0] = x1_re;
    assign xp[1][1] = x1_im;
    assign xp[2][0] = x2_re;
    assign xp[2][1] = x2_im;

    generate
        if (IN_REG != 0) begin : g_inreg
            assign xs = st_q.x;
        end else begin : g_nore
            assign xs = xp;
        end
    endgenerate

    logic signed [IW-1:0] t1 [2];
    logic signed [IW-1:0] t2 [2];
    logic signed [IW-1:0] c15 [2];
    logic signed [IW-1:0] ks [2];

    for (genvar p = 0; p < 2; p++) begin : g_part
        r3dft_preadd #(.W(W), .IW(IW)) u_pre (
            .a    ($signed(xs[1][p])),
            .b    ($signed(xs[2][p])),
            .sum  (t1[p]),
            .diff (t2[p])
        );
        r3dft_cmul #(.IW(IW), .KIND(CM_THREE_HALVES)) u_c15 (
            .v (t1[p]),
            .p (c15[p])
        );
        r3dft_cmul #(.IW(IW), .KIND(CM_SIN60)) u_s60 (
            .v (t2[p]),
            .p (ks[p])
        );
    end

    logic signed [IW-1:0] a0 [2];
    logic signed [IW-1:0] s  [2];
    logic signed [IW-1:0] wd [3][2];
    logic signed [IW-1:0] sc [3][2];

    always_comb begin
        st_d   = st_q;
        st_d.x = xp;
        for (int p = 0; p < 2; p++) begin
            a0[p]    = IW'($signed(xs[0][p]));
            wd[0][p] = a0[p] + t1[p];
            s[p]     = wd[0][p] - c15[p];
        end
        // -j rotation of the sin60 term: re takes +k(im), im takes -k(re)
        wd[1][0] = s[0] + ks[1];
        wd[1][1] = s[1] - ks[0];
        wd[2][0] = s[0] - ks[1];
        wd[2][1] = s[1] + ks[0];
        for (int k = 0; k < 3; k++) begin
            for (int p = 0; p < 2; p++) begin
                sc[k][p]     = wd[k][p] >>> SHIFT;
                st_d.y[k][p] = sc[k][p][W-1:0];
                AST_NO_OVERFLOW: assert (sc[k][p][IW-1:W-1] == '0 || sc[k][p][IW-1:W-1] == '1)
                    else $error("scaled bin exceeds output width"); // R3
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign y0_re = st_q.y[0][0];
    assign y0_im = st_q.y[0][1];
    assign y1_re = st_q.y[1][0];
    assign y1_im = st_q.y[1][1];
    assign y2_re = st_q.y[2][0];
    assign y2_im = st_q.y[2][1];

    // cycles since reset, saturating at LAT, for the temporal checks
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   warm_q <= '0;
        else if (warm_q != 2'(LAT))   warm_q <= warm_q + 2'd1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (y0_re == 0 && y0_im == 0 && y1_re == 0 && y1_im == 0 && y2_re == 0 && y2_im == 0))
        else $error("outputs not cleared by reset"); // R6

    AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'(LAT) && $past(x0_re, LAT) == 0 && $past(x0_im, LAT) == 0 &&
         $past(x1_re, LAT) == 0 && $past(x1_im, LAT) == 0 &&
         $past(x2_re, LAT) == 0 && $past(x2_im, LAT) == 0)
        |-> (y0_re == 0 && y0_im == 0 && y1_re == 0 && y1_im == 0 && y2_re == 0 && y2_im == 0))
        else $error("zero input gave nonzero output"); // R8

    AST_EQUAL_PAIR_SYM: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'(LAT) && $past(x1_re, LAT) == $past(x2_re, LAT) &&
         $past(x1_im, LAT) == $past(x2_im, LAT))
        |-> (y1_re == y2_re && y1_im == y2_im))
        else $error("bins 1 and 2 differ for equal samples"); // R7

    AST_DC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'(LAT) && $past(x1_re, LAT) == 0 && $past(x2_re, LAT) == 0)
        |-> (y0_re == W'($past(x0_re, LAT) >>> SHIFT)))
        else $error("bin 0 not due at fixed latency"); // R5
endmodule

// File: tb/r3dft_pe_test.sv
module r3dft_pe_test;
    localparam int W   = 18;
    localparam int SH  = 2;
    localparam int INR = 1;
    localparam int LAT = 1 + INR;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic signed [W-1:0] xr [3];
    logic signed [W-1:0] xi [3];
    logic signed [W-1:0] yr [3];
    logic signed [W-1:0] yi [3];

    int n_cmp = 0;
    int n_bad = 0;

    r3dft_pe #(.W(W), .GUARD(4), .SHIFT(SH), .IN_REG(INR)) uut (
        .clk(clk), .rst_n(rst_n),
        .x0_re(xr[0]), .x0_im(xi[0]), .x1_re(xr[1]), .x1_im(xi[1]),
        .x2_re(xr[2]), .x2_im(xi[2]),
        .y0_re(yr[0]), .y0_im(yi[0]), .y1_re(yr[1]), .y1_im(yi[1]),
        .y2_re(yr[2]), .y2_im(yi[2])
    );

    function automatic longint kfl(longint v, longint c);
        return (v * c) >>> 8;
    endfunction

    function automatic logic signed [W-1:0] fold(longint v);
        longint t;
        t = v >>> SH;
        return t[W-1:0];
    endfunction

    logic signed [W-1:0] er [3];
    logic signed [W-1:0] ei [3];

    task automatic calc_expect();
        longint a0r, a0i, t1r, t1i, t2r, t2i, sr, si;
        a0r = xr[0]; a0i = xi[0];
        t1r = longint'(xr[1]) + longint'(xr[2]);
        t1i = longint'(xi[1]) + longint'(xi[2]);
        t2r = longint'(xr[1]) - longint'(xr[2]);
        t2i = longint'(xi[1]) - longint'(xi[2]);
        sr = a0r + t1r - kfl(t1r, 384);
        si = a0i + t1i - kfl(t1i, 384);
        er[0] = fold(a0r + t1r);
        ei[0] = fold(a0i + t1i);
        er[1] = fold(sr + kfl(t2i, 222));
        ei[1] = fold(si - kfl(t2r, 222));
        er[2] = fold(sr - kfl(t2i, 222));
        ei[2] = fold(si + kfl(t2r, 222));
    endtask

    task automatic cmp(string tag, logic signed [W-1:0] act, logic signed [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_bins(string t0, string t12);
        for (int k = 0; k < 3; k++) begin
            cmp(k == 0 ? t0 : t12, yr[k], er[k]);
            cmp(k == 0 ? t0 : t12, yi[k], ei[k]);
        end
    endtask

    task automatic drive(logic signed [W-1:0] r0, logic signed [W-1:0] i0,
                         logic signed [W-1:0] r1, logic signed [W-1:0] i1,
                         logic signed [W-1:0] r2, logic signed [W-1:0] i2);
        xr[0] = r0; xi[0] = i0; xr[1] = r1; xi[1] = i1; xr[2] = r2; xi[2] = i2;
    endtask

    // drive at a falling edge, wait LAT rising edges, sample on the next falling edge
    task automatic apply_check(string t0, string t12);
        calc_expect();
        repeat (LAT) @(posedge clk);
        @(negedge clk);
        check_bins(t0, t12);
    endtask

    localparam logic signed [W-1:0] VMAX = (1 <<< (W-1)) - 1;
    localparam logic signed [W-1:0] VMIN = -(1 <<< (W-1));

    logic signed [W-1:0] grid [5];
    int unsigned lcg = 32'h1234_5678;

    function automatic logic signed [W-1:0] rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg[31:14];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        grid[0] = VMIN; grid[1] = -18'sd3; grid[2] = 18'sd0; grid[3] = 18'sd1; grid[4] = VMAX;

        // R6: reset holds outputs at zero despite nonzero inputs
        drive(18'sd100, -18'sd7, 18'sd55, 18'sd9, -18'sd300, 18'sd4);
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            cmp("R6", yr[k], '0);
            cmp("R6", yi[k], '0);
        end
        rst_n = 1'b1;

        // R8: all-zero inputs
        @(negedge clk);
        drive('0, '0, '0, '0, '0, '0);
        apply_check("R8", "R8");

        // R4: truncation toward minus infinity on the sin60 product
        @(negedge clk);
        drive('0, '0, '0, 18'sd1, '0, '0);
        apply_check("R4", "R4");
        cmp("R4", yr[1], 18'sd0);
        @(negedge clk);
        drive('0, '0, '0, '0, '0, 18'sd1);
        apply_check("R4", "R4");
        cmp("R4", yr[1], -18'sd1);

        // R5: latency exactly LAT edges
        @(negedge clk);
        drive(18'sd1000, 18'sd2000, -18'sd500, 18'sd40, 18'sd77, -18'sd900);
        apply_check("R5", "R5");
        @(negedge clk);
        drive(-18'sd4000, 18'sd123, 18'sd800, -18'sd16, -18'sd1, 18'sd5);
        @(posedge clk);
        @(negedge clk);
        check_bins("R5", "R5");   // er/ei still hold the previous set
        calc_expect();
        @(posedge clk);
        @(negedge clk);
        check_bins("R5", "R5");

        // R3: extreme corners
        @(negedge clk);
        drive(VMAX, VMAX, VMAX, VMAX, VMAX, VMAX);
        apply_check("R3", "R3");
        @(negedge clk);
        drive(VMIN, VMIN, VMIN, VMIN, VMIN, VMIN);
        apply_check("R3", "R3");
        @(negedge clk);
        drive(VMAX, VMIN, VMAX, VMIN, VMIN, VMAX);
        apply_check("R3", "R3");

        // R7: equal second and third samples
        for (int n = 0; n < 200; n++) begin
            logic signed [W-1:0] vr, vi;
            vr = rnd(); vi = rnd();
            @(negedge clk);
            drive(rnd(), rnd(), vr, vi, vr, vi);
            apply_check("R7", "R7");
            cmp("R7", yr[1], yr[2]);
            cmp("R7", yi[1], yi[2]);
        end

        // R1/R2: sweep of a five-value grid over all six parts
        for (int a = 0; a < 5; a++)
        for (int b = 0; b < 5; b++)
        for (int c = 0; c < 5; c++)
        for (int d = 0; d < 5; d++)
        for (int e = 0; e < 5; e++)
        for (int f = 0; f < 5; f++) begin
            @(negedge clk);
            drive(grid[a], grid[b], grid[c], grid[d], grid[e], grid[f]);
            apply_check("R1", "R2");
        end

        // R1/R2: pseudo-random samples
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            drive(rnd(), rnd(), rnd(), rnd(), rnd(), rnd());
            apply_check("R1", "R2");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule